// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Register Front-End

This block sits between a simple register port and the back-end sequencer of a one-time-programmable fuse array. Software reaches a control word in three ways: a plain write, a bit-set alias and a bit-clear alias. The control word carries a fuse word address, a busy flag, a sticky error flag, a reload command and a 16-bit arming key. A data register launches fuse programming. A window of shadow words mirrors the fuse contents so that software can read them without going to the fuses.

Each access is checked against per-word program-lock and read-lock inputs before anything reaches the back-end. A legal program or reload request produces a one-cycle start pulse with an operation code, a captured address and write data. The front-end then stays busy until the back-end returns a done pulse. During a reload the back-end streams words into the shadow window. A lock violation sets the error flag and launches nothing. New operations are then refused until software clears the flag. A read-protected shadow word returns the marker 0xBADABADA.

Top module: `otp_ctl_front`

## Requirements
- R1: After reset the control word reads 0, the start pulse is low, read data is 0 and every shadow word reads 0.
- R2: The control word is at byte address 0x000 with address in bits 7:0, busy in bit 8, error in bit 9, reload in bit 10 and the key in bits 31:16, bits 15:11 reading 0. A write to 0x000 replaces it, a write to 0x004 ORs in the written bits and a write to 0x008 clears the written bits. Busy ignores all writes, and software can clear error but never set it.
- R3: A write to the data register at 0x020 starts a program only when the key field holds 0x3E77. That start clears the key to 0. With any other key the data write starts nothing.
- R4: A program start drives `seq_start` high for one cycle with `seq_op` = 0, `seq_addr` = the control address and `seq_wdata` = the written data, and sets busy. Busy stays set until `seq_done`. Later writes to the address field leave `seq_addr` unchanged while busy.
- R5: While busy, data-register writes and reload requests are ignored: no start, no data or reload-bit change.
- R6: A program start at a word whose `prog_lock` bit is set, or whose address is at or above NWORDS, starts nothing, leaves busy clear, sets error and clears the key.
- R7: Setting bit 10 while idle and error-free starts a reload (`seq_op` = 1). Busy and bit 10 stay high until `seq_done`, and both clear together then. While the reload runs, each `ld_valid` cycle writes `ld_data` into shadow word `ld_idx`.
- R8: Shadow word i is read at byte address 0x400 + 16*i. If `read_lock[i]` is set, the read returns 0xBADABADA and sets error.
- R9: A write to a shadow word stores the data, except during a reload or when the word's `prog_lock` bit is set. In those cases error is set and the word keeps its contents.
- R10: While error is set, data-register writes and reload requests start nothing, shadow writes are ignored and shadow reads return 0xBADABADA.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_re`. Address 0x020 reads back the last accepted data. Unmapped or misaligned addresses, and shadow indices at or above NWORDS, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Single-cycle write strobe |
| reg_re | input | 1 | Single-cycle read strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| prog_lock | input | NWORDS | Per-word program lock |
| read_lock | input | NWORDS | Per-word read lock |
| seq_start | output | 1 | One-cycle operation launch |
| seq_op | output | 1 | 0 program, 1 reload |
| seq_addr | output | 8 | Captured fuse word address |
| seq_wdata | output | 32 | Captured program data |
| seq_done | input | 1 | Back-end completion pulse |
| ld_valid | input | 1 | Reload word valid |
| ld_idx | input | IDX_W | Reload word index |
| ld_data | input | 32 | Reload word data |

## Verification
The assertions assume the back-end raises `seq_done` only while an operation is in flight, and raises `ld_valid` only during a reload. They also assume the register port never asserts its write and read strobes in the same cycle. The directed tasks keep to these assumptions: they drive one strobe at a time, return done only after a start has been observed, and stream reload words between the reload start and its done. The lock inputs change only while the port is idle.

// File: rtl/otp_ctl_front.sv
module otp_ctl_front #(
  parameter int NWORDS = 16,
  parameter int IDX_W  = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NWORDS-1:0] prog_lock,
  input  logic [NWORDS-1:0] read_lock,
  output logic              seq_start,
  output logic              seq_op,
  output logic [7:0]        seq_addr,
  output logic [31:0]       seq_wdata,
  input  logic              seq_done,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [31:0]       ld_data
);
  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_CSET = 12'h004;
  localparam logic [11:0] A_CCLR = 12'h008;
  localparam logic [11:0] A_DATA = 12'h020;
  localparam logic [11:0] A_SHAD = 12'h400;
  localparam logic [15:0] KEY    = 16'h3E77;
  localparam logic [31:0] MARKER = 32'hBADA_BADA;
  localparam logic [7:0]  NW8    = 8'(NWORDS);

  logic [7:0]  addr_q;
  logic        busy_q, err_q, reload_q;
  logic [15:0] unlock_q;
  logic [31:0] data_q;
  logic [31:0] shadow_q [NWORDS];
  logic        start_q, op_q;
  logic [7:0]  saddr_q;
  logic [31:0] swdata_q, rdata_q;

  wire [31:0] ctrl_cur = {unlock_q, 5'b0, reload_q, err_q, busy_q, addr_q};
  wire is_ctrl = (reg_addr == A_CTRL) || (reg_addr == A_CSET) || (reg_addr == A_CCLR);
  wire is_data = (reg_addr == A_DATA);

  wire [11:0]      sh_off   = reg_addr - A_SHAD;
  wire [7:0]       sh_wide  = sh_off[11:4];
  wire             sh_hit   = (reg_addr >= A_SHAD) && (sh_off[3:0] == 4'd0) && (sh_wide < NW8);
  wire [IDX_W-1:0] sh_idx   = sh_wide[IDX_W-1:0];
  wire             sh_rlock = read_lock[sh_idx];
  wire             sh_plock = prog_lock[sh_idx];

  wire addr_ok = (addr_q < NW8);
  wire tgt_locked = !addr_ok || prog_lock[addr_q[IDX_W-1:0]];

  logic [31:0] ctrl_new;
  always_comb begin
    case (reg_addr)
      A_CSET:  ctrl_new = ctrl_cur | reg_wdata;
      A_CCLR:  ctrl_new = ctrl_cur & ~reg_wdata;
      default: ctrl_new = reg_wdata;
    endcase
  end

  wire ctrl_wr = reg_we && is_ctrl;
  wire data_wr = reg_we && is_data;
  wire sh_wr   = reg_we && sh_hit;
  wire sh_rd   = reg_re && sh_hit;
  wire idle_ok = !busy_q && !err_q;
  wire want_reload = ctrl_wr && ctrl_new[10] && !reload_q && idle_ok;
  wire want_prog   = data_wr && idle_ok && (unlock_q == KEY);

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = 32'd0;
    if (is_ctrl)      rd_mux = ctrl_cur;
    else if (is_data) rd_mux = data_q;
    else if (sh_hit)  rd_mux = (err_q || sh_rlock) ? MARKER : shadow_q[sh_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      reload_q <= 1'b0;
      unlock_q <= '0;
      data_q   <= '0;
      start_q  <= 1'b0;
      op_q     <= 1'b0;
      saddr_q  <= '0;
      swdata_q <= '0;
      rdata_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (ctrl_wr) begin
        addr_q   <= ctrl_new[7:0];
        unlock_q <= ctrl_new[31:16];
        if (!ctrl_new[9]) err_q <= 1'b0;
      end
      if (want_reload) begin
        reload_q <= 1'b1;
        busy_q   <= 1'b1;
        start_q  <= 1'b1;
        op_q     <= 1'b1;
      end
      if (data_wr && idle_ok) data_q <= reg_wdata;
      if (want_prog) begin
        unlock_q <= '0;
        if (tgt_locked) begin
          err_q <= 1'b1;
        end else begin
          busy_q   <= 1'b1;
          start_q  <= 1'b1;
          op_q     <= 1'b0;
          saddr_q  <= addr_q;
          swdata_q <= reg_wdata;
        end
      end
      if (sh_wr && !err_q && (reload_q || sh_plock)) err_q <= 1'b1;
      if (sh_rd && !err_q && sh_rlock) err_q <= 1'b1;
      if (seq_done && busy_q) begin
        busy_q   <= 1'b0;
        reload_q <= 1'b0;
      end
      if (reg_re) rdata_q <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) shadow_q[i] <= '0;
    end else begin
      if (ld_valid && reload_q)
        shadow_q[ld_idx] <= ld_data;
      else if (sh_wr && !err_q && !reload_q && !sh_plock)
        shadow_q[sh_idx] <= reg_wdata;
    end
  end

  assign reg_rdata = rdata_q;
  assign seq_start = start_q;
  assign seq_op    = op_q;
  assign seq_addr  = saddr_q;
  assign seq_wdata = swdata_q;
endmodule

// File: rtl/otp_ctl_front_chk.sv
module otp_ctl_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        err,
  input logic        reload,
  input logic [15:0] unlock,
  input logic        seq_start,
  input logic        seq_op,
  input logic [7:0]  seq_addr,
  input logic        seq_done
);
  assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !seq_done |=> !seq_start);
  assert_busy_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> seq_start);
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !seq_start |-> $stable(seq_addr));
  assert_key_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start && !seq_op |-> unlock == 16'h0);
  assert_reload_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> busy);
  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && busy |=> !busy && !reload);
  assert_err_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !seq_start);
endmodule

bind otp_ctl_front otp_ctl_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .err(err_q), .reload(reload_q),
  .unlock(unlock_q), .seq_start(seq_start), .seq_op(seq_op),
  .seq_addr(seq_addr), .seq_done(seq_done)
);

// File: tb/otp_ctl_front_bench.sv
`timescale 1ns/1ps
module otp_ctl_front_bench;
  localparam int NW = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_re = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [NW-1:0] prog_lock = 0, read_lock = 0;
  logic seq_start, seq_op;
  logic [7:0] seq_addr;
  logic [31:0] seq_wdata;
  logic seq_done = 0, ld_valid = 0;
  logic [IW-1:0] ld_idx = 0;
  logic [31:0] ld_data = 0;

  int checks = 0, errors = 0, starts = 0;
  logic last_op;
  logic [7:0] last_addr;
  logic [31:0] last_wd;

  always #2.5 clk = ~clk;

  otp_ctl_front #(.NWORDS(NW)) u_otp_ctl_front (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .prog_lock(prog_lock), .read_lock(read_lock), .seq_start(seq_start),
    .seq_op(seq_op), .seq_addr(seq_addr), .seq_wdata(seq_wdata),
    .seq_done(seq_done), .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data)
  );

  always @(negedge clk) if (seq_start) begin
    starts++;
    last_op = seq_op;
    last_addr = seq_addr;
    last_wd = seq_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #0.5 reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); #0.5 reg_re = 0; d = reg_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk); seq_done = 1;
    @(negedge clk); #0.5 seq_done = 0;
  endtask

  task automatic load(input int i, input logic [31:0] d);
    @(negedge clk); ld_valid = 1; ld_idx = IW'(i); ld_data = d;
    @(negedge clk); #0.5 ld_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 start", {31'd0, seq_start}, 0);
    check("R1 rdata", reg_rdata, 0);
    rd(12'h000, d); check("R1 ctrl", d, 0);
    rd(12'h430, d); check("R1 shadow", d, 0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    wr(12'h000, 32'h12); rd(12'h000, d); check("R2 plain", d, 32'h12);
    wr(12'h004, 32'h21); rd(12'h000, d); check("R2 set", d, 32'h33);
    wr(12'h008, 32'h03); rd(12'h000, d); check("R2 clr", d, 32'h30);
    wr(12'h004, 32'h300); rd(12'h000, d); check("R2 busy/err not settable", d, 32'h30);
    wr(12'h000, 0);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    int s0 = starts;
    wr(12'h000, 32'h2); wr(12'h020, 32'h1234);
    wr(12'h000, 32'h3E76_0002); wr(12'h020, 32'h1234);
    check("R3 no key no start", starts, s0);
    rd(12'h000, d); check("R3 ctrl idle", d, 32'h3E76_0002);
    wr(12'h000, 0);
  endtask

  task automatic t_program();
    logic [31:0] d;
    int s0 = starts;
    wr(12'h000, 32'h3E77_0005); wr(12'h020, 32'hA5A5_0001);
    check("R3 start", starts, s0 + 1);
    check("R4 op", {31'd0, last_op}, 0);
    check("R4 addr", {24'd0, last_addr}, 5);
    check("R4 data", last_wd, 32'hA5A5_0001);
    rd(12'h000, d); check("R3 key cleared busy set", d, 32'h0000_0105);
    wr(12'h000, 32'h9);
    check("R4 addr held", {24'd0, seq_addr}, 5);
    rd(12'h000, d); check("R4 ctrl addr moved", d, 32'h109);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    int s0 = starts;
    wr(12'h000, 32'h3E77_0007); wr(12'h020, 32'hFFFF);
    wr(12'h004, 32'h400);
    check("R5 no start", starts, s0);
    rd(12'h000, d); check("R5 reload ignored", d, 32'h3E77_0107);
    rd(12'h020, d); check("R5 data ignored", d, 32'hA5A5_0001);
    done_pulse();
    rd(12'h000, d); check("R4 busy released", d, 32'h3E77_0007);
    wr(12'h000, 0);
  endtask

  task automatic t_lockprog();
    logic [31:0] d;
    int s0 = starts;
    prog_lock = 16'h0008;
    wr(12'h000, 32'h3E77_0003); wr(12'h020, 32'h1);
    check("R6 locked no start", starts, s0);
    rd(12'h000, d); check("R6 err set", d, 32'h203);
    wr(12'h008, 32'h200); rd(12'h000, d); check("R2 err cleared", d, 32'h3);
    wr(12'h000, 32'h3E77_0020); wr(12'h020, 32'h1);
    check("R6 range no start", starts, s0);
    rd(12'h000, d); check("R6 range err", d, 32'h220);
    wr(12'h000, 0);
  endtask

  task automatic t_errblock();
    logic [31:0] d;
    int s0 = starts;
    wr(12'h000, 32'h3E77_0003); wr(12'h020, 32'h1);
    wr(12'h004, 32'h3E77_0000); wr(12'h008, 32'hFF); wr(12'h004, 32'h5);
    wr(12'h020, 32'h77); wr(12'h004, 32'h400);
    check("R10 no start", starts, s0);
    rd(12'h000, d); check("R10 ctrl", d, 32'h3E77_0205);
    rd(12'h400, d); check("R10 marker", d, 32'hBADA_BADA);
    wr(12'h000, 0); prog_lock = 0;
  endtask

  task automatic t_reload();
    logic [31:0] d;
    int s0 = starts;
    wr(12'h004, 32'h400);
    check("R7 start", starts, s0 + 1);
    check("R7 op", {31'd0, last_op}, 1);
    rd(12'h000, d); check("R7 busy+reload", d, 32'h500);
    for (int i = 0; i < NW; i++) load(i, 32'hC0DE_0000 + i);
    wr(12'h410, 32'hDEAD);
    rd(12'h000, d); check("R9 write in reload err", d, 32'h700);
    wr(12'h008, 32'h200);
    done_pulse();
    rd(12'h000, d); check("R7 cleared", d, 0);
    rd(12'h410, d); check("R9 unchanged", d, 32'hC0DE_0001);
    rd(12'h4F0, d); check("R8 last word", d, 32'hC0DE_000F);
  endtask

  task automatic t_shadow_rd();
    logic [31:0] d;
    read_lock = 16'h0004;
    rd(12'h420, d); check("R8 protected", d, 32'hBADA_BADA);
    rd(12'h000, d); check("R8 err", d, 32'h200);
    wr(12'h008, 32'h200); read_lock = 0;
    rd(12'h420, d); check("R8 open", d, 32'hC0DE_0002);
  endtask

  task automatic t_shadow_wr();
    logic [31:0] d;
    wr(12'h440, 32'h5555_AAAA);
    rd(12'h440, d); check("R9 store", d, 32'h5555_AAAA);
    prog_lock = 16'h0010;
    wr(12'h440, 32'h1111);
    rd(12'h000, d); check("R9 locked err", d, 32'h200);
    wr(12'h008, 32'h200); prog_lock = 0;
    rd(12'h440, d); check("R9 locked unchanged", d, 32'h5555_AAAA);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    int s0 = starts;
    rd(12'h0C0, d); check("R11 unmapped", d, 0);
    rd(12'h404, d); check("R11 misaligned", d, 0);
    rd(12'h500, d); check("R11 beyond", d, 0);
    wr(12'h020, 32'hCAFE_F00D);
    rd(12'h020, d); check("R11 data readback", d, 32'hCAFE_F00D);
    check("R3 no key", starts, s0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_unlock();
    t_program();
    t_busy();
    t_lockprog();
    t_errblock();
    t_reload();
    t_shadow_rd();
    t_shadow_wr();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule